// File: doc/BRIEF.md
# Exception and Status Control Coprocessor

This block is the system-control coprocessor beside a 32-bit RISC core. It keeps four architectural registers: the bad-address, status, cause and exception-PC registers. The core reads and writes them by register number through a move port. In the same cycle that an exception is taken, the block raises a redirect and presents the fixed kernel vector. At the next clock edge it records the cause code and the return PC. It also pushes a three-level mode/enable stack so that the handler runs in kernel mode with interrupts off.

Three sources can start an exception. The first is a synchronous trap request from the pipeline, which carries a code and an optional faulting address. The second is the block's own check of data addresses made in user mode. The third is the set of eight hardware interrupt lines, each gated by its own mask bit and by the global enable. An exception-return command pops the mode/enable stack, which restores the earlier privilege level and interrupt enable. An interrupt that arrives while interrupts are off is held and is taken after interrupts are enabled again.

Top module: `trapCoproc`

## Requirements
- R1: Register numbers select the registers: 8 is bad address, 12 is status, 13 is cause and 14 is exception PC. Any other number reads as zero. In kernel mode a move-to writes status bits 15..8 and 5..0, cause bits 15..8, and all 32 bits of the exception PC.
- R2: A trap request writes its 4-bit code into cause bits 5..2 and writes the trapping instruction's PC (input `excPc`) into the exception PC. The codes are: 4 load address, 5 store address, 6 fetch bus error, 7 data bus error, 12 overflow, 15 floating point.
- R3: A taken interrupt writes code 0 to cause bits 5..2 and writes the next-instruction PC (input `nextPc`) into the exception PC.
- R4: When an exception is taken, `redirect` is high in that same cycle and `redirectPc` equals 0x80000180. At the next edge status bits 5..0 shift left by two, which clears the current pair. Each pair holds the mode in its upper bit (1 = user) and the enable in its lower bit (1 = interrupts on). Current is bits 1..0, previous is bits 3..2 and old is bits 5..4.
- R5: An exception return in kernel mode moves bits 3..2 into 1..0 and bits 5..4 into 3..2, and leaves bits 5..4 unchanged. An exception return in user mode has no effect.
- R6: Status bits 15..8 mask lines 7..0 one to one. An interrupt is taken only when a line's pending bit and its mask bit are both set and the current enable bit is 1.
- R7: A high interrupt line sets its pending bit in cause bits 15..8 at the next edge. The bit stays set while interrupts are off, so the interrupt is taken in the first cycle after they are enabled again. A kernel write to cause replaces the pending bits.
- R8: In user mode every move-to is ignored. Reads work in both modes.
- R9: In user mode, a data access with address bit 31 set raises code 4 for a load or code 5 for a store, and latches the access address into bad address. Accesses below 0x80000000, and any access made in kernel mode, raise nothing.
- R10: A trap request with code 4, 5, 6 or 7 latches `faultAddr` into bad address. Other codes leave bad address unchanged.
- R11: Priority runs trap request first, then address fault, then interrupt. A losing interrupt stays pending.
- R12: Reset clears every register. This leaves kernel mode with interrupts off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 5 | Register number for move-from and move-to |
| regWrEn | input | 1 | Move-to strobe |
| regWrData | input | 32 | Move-to data |
| regRdData | output | 32 | Move-from data (combinational) |
| excReq | input | 1 | Synchronous trap request |
| excCode | input | 4 | Code of the trap request |
| excPc | input | 32 | PC of the current instruction |
| nextPc | input | 32 | PC of the next instruction to run |
| faultAddr | input | 32 | Faulting address sent with a trap request |
| dataAccValid | input | 1 | A data access is issued this cycle |
| dataAccWrite | input | 1 | The access is a store |
| dataAddr | input | 32 | Data access address |
| irqLines | input | 8 | Hardware interrupt lines |
| eretReq | input | 1 | Exception-return command |
| redirect | output | 1 | An exception is taken this cycle |
| redirectPc | output | 32 | Vector address while redirect is high, zero otherwise |
| userMode | output | 1 | Current mode bit |

## Verification
`redirect` and `redirectPc` are combinational. The bench checks them one time step after it drives the cause, in the same cycle. Cause, exception PC, bad address and status change at the edge that ends that cycle, so the bench reads them through the move port after that edge. An interrupt line takes one edge to reach its pending bit, which puts the redirect one full cycle after the line was driven. The bench checks that redirect is low in the driving cycle and high in the following one. The deferred-interrupt case is checked the same way: redirect must be high in the cycle directly after the edge that carries the return command.

// File: rtl/trapPkg.sv
`timescale 1ns/1ps
package trapPkg;
  localparam int XLEN  = 32;
  localparam int NIRQ  = 8;
  localparam int SEL_W = 5;
  localparam int CODE_W = 4;
  localparam int PAIRS_W = 6;
  localparam int PEND_LSB = 8;

  localparam logic [SEL_W-1:0] SEL_BAD   = 5'd8;
  localparam logic [SEL_W-1:0] SEL_STAT  = 5'd12;
  localparam logic [SEL_W-1:0] SEL_CAUSE = 5'd13;
  localparam logic [SEL_W-1:0] SEL_EPC   = 5'd14;

  localparam logic [XLEN-1:0] KERNEL_VECTOR = 32'h8000_0180;

  typedef enum logic [CODE_W-1:0] {
    EXC_IRQ        = 4'd0,
    EXC_LOAD_ADDR  = 4'd4,
    EXC_STORE_ADDR = 4'd5,
    EXC_FETCH_BUS  = 4'd6,
    EXC_DATA_BUS   = 4'd7,
    EXC_OVERFLOW   = 4'd12,
    EXC_FLOAT      = 4'd15
  } excKind_t;

  typedef struct packed {
    logic              enter;
    logic              leave;
    logic              wrStatus;
    logic              wrCause;
    logic              wrEpc;
    logic              useNextPc;
    logic              loadBad;
    logic              badFromData;
    logic [CODE_W-1:0] code;
  } ctlStrobes_t;
endpackage

// File: rtl/trapControl.sv
`timescale 1ns/1ps
module trapControl
  import trapPkg::*;
(
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              dataAccValid,
  input  logic              dataAccWrite,
  input  logic              dataAddrMsb,
  input  logic              curUser,
  input  logic              curEnable,
  input  logic [NIRQ-1:0]   pendQ,
  input  logic [NIRQ-1:0]   maskQ,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              eretReq,
  output ctlStrobes_t       strobes,
  output logic              takeExc
);
  logic addrFault;
  logic intHit;
  logic kernelWr;
  logic busOrAddrCode;

  assign addrFault     = dataAccValid && curUser && dataAddrMsb;
  assign intHit        = curEnable && (|(pendQ & maskQ));
  assign takeExc       = excReq || addrFault || intHit;
  assign busOrAddrCode = (excCode[3:2] == 2'b01);
  assign kernelWr      = regWrEn && !curUser && !takeExc;

  always_comb begin
    strobes             = '0;
    strobes.enter       = takeExc;
    strobes.leave       = eretReq && !curUser && !takeExc;
    strobes.wrStatus    = kernelWr && (regSel == SEL_STAT);
    strobes.wrCause     = kernelWr && (regSel == SEL_CAUSE);
    strobes.wrEpc       = kernelWr && (regSel == SEL_EPC);
    if (excReq) begin
      strobes.code        = excCode;
      strobes.useNextPc   = 1'b0;
      strobes.loadBad     = busOrAddrCode;
      strobes.badFromData = 1'b0;
    end else if (addrFault) begin
      strobes.code        = dataAccWrite ? EXC_STORE_ADDR : EXC_LOAD_ADDR;
      strobes.useNextPc   = 1'b0;
      strobes.loadBad     = 1'b1;
      strobes.badFromData = 1'b1;
    end else begin
      strobes.code        = EXC_IRQ;
      strobes.useNextPc   = 1'b1;
      strobes.loadBad     = 1'b0;
      strobes.badFromData = 1'b0;
    end
  end
endmodule

// File: rtl/trapDatapath.sv
`timescale 1ns/1ps
module trapDatapath
  import trapPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [XLEN-1:0]   regWrData,
  input  logic [XLEN-1:0]   excPc,
  input  logic [XLEN-1:0]   nextPc,
  input  logic [XLEN-1:0]   faultAddr,
  input  logic [XLEN-1:0]   dataAddr,
  input  logic [NIRQ-1:0]   irqLines,
  output logic [XLEN-1:0]   regRdData,
  output logic              curUser,
  output logic              curEnable,
  output logic [NIRQ-1:0]   pendQ,
  output logic [NIRQ-1:0]   maskQ,
  output logic [XLEN-1:0]   statusWord,
  output logic [XLEN-1:0]   causeWord,
  output logic [XLEN-1:0]   epcWord
);
  localparam int STAT_PAD = XLEN - NIRQ - PEND_LSB;

  logic [PAIRS_W-1:0] pairsQ;
  logic [CODE_W-1:0]  codeQ;
  logic [XLEN-1:0]    epcQ;
  logic [XLEN-1:0]    badQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairsQ <= '0;
      maskQ  <= '0;
    end else if (strobes.enter) begin
      pairsQ <= {pairsQ[PAIRS_W-3:0], 2'b00};
    end else if (strobes.leave) begin
      pairsQ <= {pairsQ[PAIRS_W-1:PAIRS_W-2], pairsQ[PAIRS_W-1:2]};
    end else if (strobes.wrStatus) begin
      pairsQ <= regWrData[PAIRS_W-1:0];
      maskQ  <= regWrData[PEND_LSB +: NIRQ];
    end
  end

  for (genvar i = 0; i < NIRQ; i++) begin : g_pend
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        pendQ[i] <= 1'b0;
      else if (strobes.wrCause)
        pendQ[i] <= regWrData[PEND_LSB + i] | irqLines[i];
      else
        pendQ[i] <= pendQ[i] | irqLines[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
      epcQ  <= '0;
      badQ  <= '0;
    end else begin
      if (strobes.enter) begin
        codeQ <= strobes.code;
        epcQ  <= strobes.useNextPc ? nextPc : excPc;
        if (strobes.loadBad)
          badQ <= strobes.badFromData ? dataAddr : faultAddr;
      end else if (strobes.wrEpc) begin
        epcQ <= regWrData;
      end
    end
  end

  assign curUser    = pairsQ[1];
  assign curEnable  = pairsQ[0];
  assign statusWord = {{STAT_PAD{1'b0}}, maskQ, 2'b00, pairsQ};
  assign causeWord  = {{STAT_PAD{1'b0}}, pendQ, 2'b00, codeQ, 2'b00};
  assign epcWord    = epcQ;

  always_comb begin
    case (regSel)
      SEL_BAD:   regRdData = badQ;
      SEL_STAT:  regRdData = statusWord;
      SEL_CAUSE: regRdData = causeWord;
      SEL_EPC:   regRdData = epcQ;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/trapCoproc.sv
`timescale 1ns/1ps
module trapCoproc
  import trapPkg::*;
#(
  parameter logic [XLEN-1:0] VECTOR_PC = KERNEL_VECTOR
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWrEn,
  input  logic [XLEN-1:0]   regWrData,
  output logic [XLEN-1:0]   regRdData,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [XLEN-1:0]   excPc,
  input  logic [XLEN-1:0]   nextPc,
  input  logic [XLEN-1:0]   faultAddr,
  input  logic              dataAccValid,
  input  logic              dataAccWrite,
  input  logic [XLEN-1:0]   dataAddr,
  input  logic [NIRQ-1:0]   irqLines,
  input  logic              eretReq,
  output logic              redirect,
  output logic [XLEN-1:0]   redirectPc,
  output logic              userMode
);
  ctlStrobes_t     strobes;
  logic            takeExc;
  logic            curUser;
  logic            curEnable;
  logic [NIRQ-1:0] pendQ;
  logic [NIRQ-1:0] maskQ;
  logic [XLEN-1:0] statusWord;
  logic [XLEN-1:0] causeWord;
  logic [XLEN-1:0] epcWord;

  trapControl u_ctl (
    .excReq      (excReq),
    .excCode     (excCode),
    .dataAccValid(dataAccValid),
    .dataAccWrite(dataAccWrite),
    .dataAddrMsb (dataAddr[XLEN-1]),
    .curUser     (curUser),
    .curEnable   (curEnable),
    .pendQ       (pendQ),
    .maskQ       (maskQ),
    .regWrEn     (regWrEn),
    .regSel      (regSel),
    .eretReq     (eretReq),
    .strobes     (strobes),
    .takeExc     (takeExc)
  );

  trapDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .regSel    (regSel),
    .regWrData (regWrData),
    .excPc     (excPc),
    .nextPc    (nextPc),
    .faultAddr (faultAddr),
    .dataAddr  (dataAddr),
    .irqLines  (irqLines),
    .regRdData (regRdData),
    .curUser   (curUser),
    .curEnable (curEnable),
    .pendQ     (pendQ),
    .maskQ     (maskQ),
    .statusWord(statusWord),
    .causeWord (causeWord),
    .epcWord   (epcWord)
  );

  assign redirect   = takeExc;
  assign redirectPc = takeExc ? VECTOR_PC : '0;
  assign userMode   = curUser;
endmodule

// File: rtl/trapCoprocChk.sv
`timescale 1ns/1ps
module trapCoprocChk
  import trapPkg::*;
#(
  parameter logic [XLEN-1:0] VEC = KERNEL_VECTOR
) (
  input logic                clk,
  input logic                rstN,
  input logic                redirect,
  input logic [XLEN-1:0]     redirectPc,
  input logic                excReq,
  input logic [CODE_W-1:0]   excCode,
  input logic [XLEN-1:0]     excPc,
  input logic                eretReq,
  input logic                userMode,
  input logic                regWrEn,
  input logic [SEL_W-1:0]    regSel,
  input logic [PAIRS_W-1:0]  pairs,
  input logic [CODE_W-1:0]   causeCode,
  input logic [XLEN-1:0]     epcWord
);
  assert_vector_R4: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> redirectPc == VEC);

  assert_push_R4: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> pairs == {$past(pairs[3:0]), 2'b00});

  assert_pop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (eretReq && !redirect && !userMode) |=>
      (pairs[3:0] == $past(pairs[5:2])) && (pairs[5:4] == $past(pairs[5:4])));

  assert_trap_taken_R11: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> redirect);

  assert_trap_record_R2: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (causeCode == $past(excCode)) && (epcWord == $past(excPc)));

  assert_user_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == SEL_STAT && userMode && !redirect) |=> $stable(pairs));
endmodule

bind trapCoproc trapCoprocChk #(.VEC(VECTOR_PC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .redirect  (redirect),
  .redirectPc(redirectPc),
  .excReq    (excReq),
  .excCode   (excCode),
  .excPc     (excPc),
  .eretReq   (eretReq),
  .userMode  (userMode),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .pairs     (statusWord[5:0]),
  .causeCode (causeWord[5:2]),
  .epcWord   (epcWord)
);

// File: tb/tb_trapCoproc.sv
`timescale 1ns/1ps
module tb_trapCoproc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        excReq = 1'b0;
  logic [3:0]  excCode = '0;
  logic [31:0] excPc = '0;
  logic [31:0] nextPc = '0;
  logic [31:0] faultAddr = '0;
  logic        dataAccValid = 1'b0;
  logic        dataAccWrite = 1'b0;
  logic [31:0] dataAddr = '0;
  logic [7:0]  irqLines = '0;
  logic        eretReq = 1'b0;
  logic        redirect;
  logic [31:0] redirectPc;
  logic        userMode;

  int nChk = 0;
  int nFail = 0;
  logic [31:0] expBad = '0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  trapCoproc dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .excReq(excReq),
    .excCode(excCode), .excPc(excPc), .nextPc(nextPc), .faultAddr(faultAddr),
    .dataAccValid(dataAccValid), .dataAccWrite(dataAccWrite), .dataAddr(dataAddr),
    .irqLines(irqLines), .eretReq(eretReq), .redirect(redirect),
    .redirectPc(redirectPc), .userMode(userMode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock edge, then strobes drop 1 ns after it
  task automatic edgeStep();
    @(posedge clk);
    #1;
    excReq = 1'b0; eretReq = 1'b0; regWrEn = 1'b0;
    dataAccValid = 1'b0; dataAccWrite = 1'b0; irqLines = '0;
  endtask

  task automatic rd(input logic [4:0] s, output logic [31:0] v);
    regSel = s;
    #0.5;
    v = regRdData;
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    regSel = s; regWrData = d; regWrEn = 1'b1;
    edgeStep();
  endtask

  task automatic trap(input logic [3:0] c, input logic [31:0] pc, input logic [31:0] fa);
    excReq = 1'b1; excCode = c; excPc = pc; faultAddr = fa;
  endtask

  // enter kernel, load mask with user/enabled in previous pair, clear pending, return
  task automatic setMask(input logic [7:0] m);
    trap(4'd12, 32'h0, 32'h0);
    edgeStep();
    wr(5'd12, {16'h0, m, 8'h0C});
    wr(5'd13, 32'h0);
    eretReq = 1'b1;
    edgeStep();
  endtask

  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [3:0] codes [6];
    codes[0] = 4'd4; codes[1] = 4'd5; codes[2] = 4'd6;
    codes[3] = 4'd7; codes[4] = 4'd12; codes[5] = 4'd15;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R12 reset state
    rd(5'd8, rv);  chk("R12 bad addr", rv, 32'h0);
    rd(5'd12, rv); chk("R12 status", rv, 32'h0);
    rd(5'd13, rv); chk("R12 cause", rv, 32'h0);
    rd(5'd14, rv); chk("R12 epc", rv, 32'h0);
    chk("R12 userMode", {31'h0, userMode}, 32'h0);
    chk("R12 redirect", {31'h0, redirect}, 32'h0);

    // R1 register access in kernel mode
    wr(5'd14, 32'h1234_5678);
    rd(5'd14, rv); chk("R1 epc write", rv, 32'h1234_5678);
    wr(5'd12, 32'h0000_A50C);
    rd(5'd12, rv); chk("R1 status write", rv, 32'h0000_A50C);
    rd(5'd9, rv);  chk("R1 unmapped read", rv, 32'h0);

    setMask(8'h00);
    rd(5'd12, rv); chk("R5 pop to user enabled", rv, 32'h0000_0003);
    chk("R5 userMode after return", {31'h0, userMode}, 32'h1);

    // R2 R4 R10 sweep over trap codes
    for (int k = 0; k < 6; k++) begin
      trap(codes[k], 32'h0040_0000 + k * 4, 32'h1000_0000 + k);
      #0.5;
      chk("R4 redirect", {31'h0, redirect}, 32'h1);
      chk("R4 vector", redirectPc, 32'h8000_0180);
      edgeStep();
      if (codes[k] >= 4 && codes[k] <= 7) expBad = 32'h1000_0000 + k;
      rd(5'd13, rv); chk("R2 code", {28'h0, rv[5:2]}, {28'h0, codes[k]});
      rd(5'd14, rv); chk("R2 epc", rv, 32'h0040_0000 + k * 4);
      rd(5'd8, rv);  chk("R10 bad addr", rv, expBad);
      rd(5'd12, rv); chk("R4 stack push", {26'h0, rv[5:0]}, 32'h0C);
      eretReq = 1'b1;
      edgeStep();
      rd(5'd12, rv); chk("R5 stack pop", {26'h0, rv[5:0]}, 32'h03);
    end

    // R8 user-mode writes ignored, R5 user return ignored
    wr(5'd12, 32'h0);
    rd(5'd12, rv); chk("R8 status write ignored", rv, 32'h0000_0003);
    wr(5'd14, 32'hDEAD_BEEF);
    rd(5'd14, rv); chk("R8 epc write ignored", rv, 32'h0040_0014);
    eretReq = 1'b1;
    edgeStep();
    rd(5'd12, rv); chk("R5 user return ignored", rv, 32'h0000_0003);

    // R9 user address check
    dataAccValid = 1'b1; dataAccWrite = 1'b0; dataAddr = 32'h8000_0010; excPc = 32'h0040_0100;
    #0.5 chk("R9 load fault redirect", {31'h0, redirect}, 32'h1);
    edgeStep();
    rd(5'd13, rv); chk("R9 load code", {28'h0, rv[5:2]}, 32'd4);
    rd(5'd8, rv);  chk("R9 load bad addr", rv, 32'h8000_0010);
    rd(5'd14, rv); chk("R9 load epc", rv, 32'h0040_0100);
    eretReq = 1'b1; edgeStep();
    dataAccValid = 1'b1; dataAccWrite = 1'b1; dataAddr = 32'hFFFF_FFF0;
    edgeStep();
    rd(5'd13, rv); chk("R9 store code", {28'h0, rv[5:2]}, 32'd5);
    rd(5'd8, rv);  chk("R9 store bad addr", rv, 32'hFFFF_FFF0);
    expBad = 32'hFFFF_FFF0;
    eretReq = 1'b1; edgeStep();
    dataAccValid = 1'b1; dataAddr = 32'h7FFF_FFFC;
    #0.5 chk("R9 low address no fault", {31'h0, redirect}, 32'h0);
    edgeStep();
    trap(4'd12, 32'h0, 32'h0); edgeStep();
    dataAccValid = 1'b1; dataAddr = 32'h9000_0000;
    #0.5 chk("R9 kernel access no fault", {31'h0, redirect}, 32'h0);
    edgeStep();
    eretReq = 1'b1; edgeStep();

    // R3 R6 R7 interrupt sweep over lines
    for (int i = 0; i < 8; i++) begin
      int j;
      j = (i + 3) % 8;
      setMask(8'(1 << i));
      irqLines = 8'(1 << j);
      edgeStep();
      #0.5 chk("R6 masked line not taken", {31'h0, redirect}, 32'h0);
      rd(5'd13, rv); chk("R7 pending latched", {24'h0, rv[15:8]}, 32'(1 << j));
      irqLines = 8'(1 << i); nextPc = 32'h0040_1000 + i * 4;
      #0.5 chk("R7 pending one edge later", {31'h0, redirect}, 32'h0);
      edgeStep();
      #0.5 chk("R6 enabled line taken", {31'h0, redirect}, 32'h1);
      edgeStep();
      rd(5'd13, rv); chk("R3 interrupt cause", rv, 32'(((1 << i) | (1 << j)) << 8));
      rd(5'd14, rv); chk("R3 epc is next pc", rv, 32'h0040_1000 + i * 4);
      chk("R6 disabled after entry", {31'h0, redirect}, 32'h0);
      eretReq = 1'b1; edgeStep();
      #0.5 chk("R7 deferred interrupt taken", {31'h0, redirect}, 32'h1);
      edgeStep();
      wr(5'd13, 32'h0);
      eretReq = 1'b1; edgeStep();
    end

    // R11 trap beats a pending interrupt
    setMask(8'h01);
    irqLines = 8'h01; edgeStep();
    trap(4'd12, 32'h0000_0500, 32'h0);
    edgeStep();
    rd(5'd13, rv); chk("R11 trap wins", rv, 32'h0000_0130);
    rd(5'd14, rv); chk("R11 trap epc", rv, 32'h0000_0500);
    eretReq = 1'b1; edgeStep();
    #0.5 chk("R11 interrupt still pending", {31'h0, redirect}, 32'h1);
    edgeStep();
    wr(5'd13, 32'h0);
    eretReq = 1'b1; edgeStep();
    trap(4'd15, 32'h0000_0600, 32'h5555_0000);
    dataAccValid = 1'b1; dataAddr = 32'h8000_0000;
    edgeStep();
    rd(5'd13, rv); chk("R11 trap beats address fault", {28'h0, rv[5:2]}, 32'd15);
    rd(5'd8, rv);  chk("R11 bad addr untouched", rv, expBad);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule